// File: doc/BRIEF.md
# Hierarchical Software Reset Controller

This block lets software pulse reset lines across a small SoC through one 32-bit control word on a simple register bus. Each implemented low-order bit owns one peripheral domain. Writing 1 to such a bit launches a fixed-length reset pulse on that domain's line. The bit reads back as 1 while the pulse runs and clears itself when the pulse ends.

The three top bits are global requests. Each covers a different, nested set of domains. The soft request hits every peripheral domain except the watchdog. The peripheral request also spares the GPIO banks. The system request hits every domain and also the CPU core. When several requests are active at the same time, each reset line is driven by the union of all requests that cover it.

The reset lines are registered, so each line follows its request by one clock.

Top module: `srst_ctrl`

## Requirements
- R1: After the asynchronous reset, the control word reads 0 and every reset line, including the CPU line, is low.
- R2: A write with bit value 1 at byte offset 0x4 starts a pulse on an idle implemented bit. The bit reads 1 from the cycle after the write until the pulse ends, then reads 0.
- R3: Each pulse holds its request for exactly PULSE_CYCLES clocks (default 8). The affected reset lines follow the request one clock later.
- R4: While a bit is busy, writing 0 to it does not end the pulse early, and writing 1 to it does not restart or extend the pulse.
- R5: Bit 29 (soft) asserts every implemented domain line except the watchdog (bit 1), and leaves the CPU line low.
- R6: Bit 30 (peripheral) asserts every implemented domain line except the watchdog (bit 1) and the GPIO banks (bits 2 and 3), and leaves the CPU line low.
- R7: Bit 31 (system) asserts every implemented domain line and the CPU line.
- R8: Each domain line is the OR of its own request and of every global request that covers it, so overlapping requests merge.
- R9: Implemented domain bits are 0–3, 5–8 and 11–17, and domain line i matches control bit i. Writes to bits 4, 9, 10 and 18–28 are ignored: those bits read 0 and their lines stay low.
- R10: A write to any other offset changes nothing. A read at any other offset, or with no read strobe, returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (busy bits), combinational |
| dom_rst_o | output | 29 | Active-high domain reset lines, index equals control bit |
| cpu_rst_o | output | 1 | Active-high CPU core reset |

## Verification
The main function is tried with several write patterns:
- Single-domain writes show that each bit maps to its own line.
- Each global bit written alone exposes its exclusion set, so a swapped watchdog or GPIO mask is caught.
- A global bit combined with one of its excluded domains shows that the OR merge restores the spared line.
- Writes to reserved positions and to a wrong offset show that nothing is decoded where it should not be.

Directed tests count pulse width cycle by cycle, rewrite a busy bit with 0 and with 1 mid-pulse, and stagger a global request with a per-domain request to check the merge and the separate expiry of each pulse.

// File: rtl/srst_pkg.sv
package srst_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned DOM_W = 29;

  localparam int unsigned SOFT_BIT   = 29;
  localparam int unsigned PERIPH_BIT = 30;
  localparam int unsigned SYS_BIT    = 31;

  // implemented domain positions: 0-3, 5-8, 11-17
  localparam logic [REG_W-1:0] DOM_IMPL  = 32'h0003_F9EF;
  localparam logic [REG_W-1:0] WDT_MASK  = 32'h0000_0002;
  localparam logic [REG_W-1:0] GPIO_MASK = 32'h0000_000C;
  localparam logic [REG_W-1:0] GLB_MASK  = 32'hE000_0000;
  localparam logic [REG_W-1:0] WR_MASK   = DOM_IMPL | GLB_MASK;

  localparam logic [DOM_W-1:0] SYS_COV    = DOM_IMPL[DOM_W-1:0];
  localparam logic [DOM_W-1:0] SOFT_COV   = SYS_COV & ~WDT_MASK[DOM_W-1:0];
  localparam logic [DOM_W-1:0] PERIPH_COV = SOFT_COV & ~GPIO_MASK[DOM_W-1:0];
endpackage

// File: rtl/srst_bus_dec.sv
module srst_bus_dec
  import srst_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned REG_OFFSET = 4
) (
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  busy_i,
  output logic [REG_W-1:0]  start_o,
  output logic [REG_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

  logic hit;
  assign hit = (addr_i == HIT_ADDR);

  always_comb begin
    start_o = '0;
    if (wr_en_i && hit) start_o = wdata_i & WR_MASK;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i && hit) rdata_o = busy_i;
  end
endmodule

// File: rtl/srst_pulse_chan.sv
module srst_pulse_chan #(
  parameter int unsigned PULSE_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_LOAD;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;

  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i) |=> busy_q);
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
  // R3
  expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == '0) |=> !busy_q);
endmodule

// File: rtl/srst_fanout.sv
module srst_fanout
  import srst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] busy_i,
  output logic [DOM_W-1:0] dom_rst_o,
  output logic             cpu_rst_o
);
  logic [DOM_W-1:0] dom_d;
  logic [DOM_W-1:0] dom_q;
  logic             cpu_q;

  always_comb begin
    dom_d = busy_i[DOM_W-1:0] & SYS_COV;
    if (busy_i[SOFT_BIT])   dom_d = dom_d | SOFT_COV;
    if (busy_i[PERIPH_BIT]) dom_d = dom_d | PERIPH_COV;
    if (busy_i[SYS_BIT])    dom_d = dom_d | SYS_COV;
  end

  // registered so the lines are glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dom_q <= '0;
      cpu_q <= 1'b0;
    end else begin
      dom_q <= dom_d;
      cpu_q <= busy_i[SYS_BIT];
    end
  end

  assign dom_rst_o = dom_q;
  assign cpu_rst_o = cpu_q;

  // R7
  sys_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i[SYS_BIT] |=> (cpu_rst_o && dom_rst_o == SYS_COV));
  // R5
  cpu_only_sys_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i[SYS_BIT] |=> !cpu_rst_o);
  // R6
  gpio_spared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i[SYS_BIT] && !busy_i[SOFT_BIT]) |=>
      ((dom_rst_o & GPIO_MASK[DOM_W-1:0]) == ($past(busy_i[DOM_W-1:0]) & GPIO_MASK[DOM_W-1:0])));
  // R9
  reserved_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dom_rst_o & ~SYS_COV) == '0);
endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
  import srst_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 8,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned REG_OFFSET   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [28:0]       dom_rst_o,
  output logic              cpu_rst_o
);
  logic [REG_W-1:0] start;
  logic [REG_W-1:0] busy;

  srst_bus_dec #(
    .ADDR_W    (ADDR_W),
    .REG_OFFSET(REG_OFFSET)
  ) u_dec (
    .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .busy_i (busy),
    .start_o(start),
    .rdata_o(rdata_o)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_chan
    if (WR_MASK[i]) begin : g_impl
      srst_pulse_chan #(
        .PULSE_CYCLES(PULSE_CYCLES)
      ) u_chan (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(start[i]),
        .busy_o (busy[i])
      );
    end else begin : g_rsvd
      assign busy[i] = 1'b0;
    end
  end

  srst_fanout u_fan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy),
    .dom_rst_o(dom_rst_o),
    .cpu_rst_o(cpu_rst_o)
  );

  // R10
  rd_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o != '0) |-> (rd_en_i && addr_i == ADDR_W'(REG_OFFSET)));
  // R10
  wr_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i != ADDR_W'(REG_OFFSET)) |=> ((busy & ~$past(busy)) == '0));
endmodule

// File: tb/srst_ctrl_bench.sv
module srst_ctrl_bench;
  localparam int PULSE = 8;
  localparam int NVEC  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [28:0] dom_rst;
  logic        cpu_rst;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  srst_ctrl #(.PULSE_CYCLES(PULSE)) u_srst_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .dom_rst_o(dom_rst), .cpu_rst_o(cpu_rst)
  );

  // {write data, expected readback, expected domain lines, expected cpu line}
  localparam logic [93:0] VEC [NVEC] = '{
    {32'h0000_0001, 32'h0000_0001, 29'h0000_0001, 1'b0}, // R2 dma
    {32'h0000_8000, 32'h0000_8000, 29'h0000_8000, 1'b0}, // R2 spi2
    {32'h2000_0000, 32'h2000_0000, 29'h0003_F9ED, 1'b0}, // R5 soft
    {32'h4000_0000, 32'h4000_0000, 29'h0003_F9E1, 1'b0}, // R6 periph
    {32'h8000_0000, 32'h8000_0000, 29'h0003_F9EF, 1'b1}, // R7 sys
    {32'h4000_0002, 32'h4000_0002, 29'h0003_F9E3, 1'b0}, // R8 periph+wdt
    {32'h4000_000C, 32'h4000_000C, 29'h0003_F9ED, 1'b0}, // R8 periph+gpio
    {32'h0000_0010, 32'h0000_0000, 29'h0000_0000, 1'b0}, // R9 bit 4
    {32'h1FFC_0000, 32'h0000_0000, 29'h0000_0000, 1'b0}, // R9 bits 18-28
    {32'h0002_0802, 32'h0002_0802, 29'h0002_0802, 1'b0}  // R8 rtc+uart0+wdt
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rb;
    int hi;
    repeat (3) @(negedge clk);
    // R1 reset state
    read_reg(8'h04, rb);
    check("R1 readback", rb, 32'h0);
    check("R1 dom", {3'b0, dom_rst}, 32'h0);
    check("R1 cpu", {31'b0, cpu_rst}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      do_write(8'h04, VEC[i][93:62]);
      read_reg(8'h04, rb);
      check("R2/R9 busy readback", rb, VEC[i][61:30]);
      @(negedge clk);
      check("R5-R9 dom lines", {3'b0, dom_rst}, {3'b0, VEC[i][29:1]});
      check("R5-R7 cpu line", {31'b0, cpu_rst}, {31'b0, VEC[i][0]});
      repeat (PULSE + 2) @(negedge clk);
      read_reg(8'h04, rb);
      check("R2 self-clear", rb, 32'h0);
      check("R3 lines released", {3'b0, dom_rst}, 32'h0);
      check("R3 cpu released", {31'b0, cpu_rst}, 32'h0);
    end

    // R3 pulse width on line and on readback
    do_write(8'h04, 32'h0000_0020);
    hi = 0;
    for (int k = 0; k < PULSE + 4; k++) begin
      @(negedge clk);
      if (dom_rst[5]) hi++;
    end
    check("R3 line width", hi, PULSE);

    // R4 rewrite busy bit with 0 then 1
    do_write(8'h04, 32'h0000_0001);
    hi = 0;
    for (int k = 0; k < 14; k++) begin
      wr_en = (k == 1 || k == 3);
      addr  = 8'h04;
      wdata = (k == 1) ? 32'h0 : 32'h1;
      @(negedge clk);
      wr_en = 1'b0;
      if (k == 2) begin
        read_reg(8'h04, rb);
        check("R4 write 0 ignored", rb, 32'h1);
      end
      if (dom_rst[0]) hi++;
    end
    check("R4 no extension", hi, PULSE);

    // R8 staggered soft then watchdog
    do_write(8'h04, 32'h2000_0000);
    do_write(8'h04, 32'h0000_0002);
    @(negedge clk);
    check("R8 merged", {3'b0, dom_rst}, 32'h0003_F9EF);
    check("R8 cpu low", {31'b0, cpu_rst}, 32'h0);
    repeat (7) @(negedge clk);
    check("R8 wdt alone", {3'b0, dom_rst}, 32'h0000_0002);
    repeat (4) @(negedge clk);

    // R10 wrong offsets
    do_write(8'h08, 32'h8000_0001);
    read_reg(8'h04, rb);
    check("R10 write ignored rb", rb, 32'h0);
    @(negedge clk);
    check("R10 write ignored dom", {3'b0, dom_rst}, 32'h0);
    check("R10 write ignored cpu", {31'b0, cpu_rst}, 32'h0);
    do_write(8'h04, 32'h0000_0004);
    read_reg(8'h00, rb);
    check("R10 read other offset", rb, 32'h0);
    #1 check("R10 no strobe", rdata, 32'h0);
    repeat (PULSE + 3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule